// File: doc/BRIEF.md
# BCD Iterative Multiply-Divide Sequencer

This unit carries out the repeated-addition steps of a decimal arithmetic engine whose operands are 12-digit packed BCD mantissas. A multiply step adds the first mantissa into the accumulator mantissa a programmed number of times and counts the decimal overflows in a 16-bit result word. A divide step adds repeatedly until the first decimal overflow and returns the number of additions that did not overflow. The unit also holds a signed 16x16 binary multiplier that shares the same start and done handshake. Every decimal addition runs through one 12-digit adder. The adder takes the decimal-carry flag as its carry-in.

A caller loads the operands and an operation code while the unit is idle and pulses start. The unit captures every operand on that edge. It performs one addition per clock and raises done for exactly one cycle once its results are final. After done the results stay on the outputs until the next operation. The outputs also report the cost of the operation in machine cycles, so an instruction-level timing model can charge it.

Top module: `bcd_muldiv_seq`

## Requirements
- R1: With op code 0 (multiply step) and a nonzero count n = b_i[3:0], the unit performs n additions of ar1 into ar2. The first addition takes dc_i as its carry-in and each later addition takes 0. a_o ends equal to the number of additions that carried, dc_o ends 0, and b_o equals b_i.
- R2: For a multiply step with n = 0, the unit performs no addition. It finishes with a_o = 0, while ar2_o, dc_o and b_o equal their inputs.
- R3: With op code 1 (divide step), b starts at 0 and a_o equals a_i. Each pass adds ar1 into ar2, and only the first pass uses dc_i as its carry-in. A pass that carries ends the operation with ar2_o holding that carried sum and dc_o = 1. A pass that does not carry increments b and clears dc.
- R4: A divide step stops after at most 15 additions. When none of them carries, b_o = 15 and dc_o = 0.
- R5: With op code 2, {b_o, a_o} is the 32-bit two's-complement product of a_i and b_i taken as signed 16-bit values. ar2_o and dc_o equal their inputs.
- R6: Mantissas are packed BCD, with digit k in bits 4k+3:4k and digit 0 least significant. Each digit sum of 10 or more is reduced by 10 and carries into the next digit. The carry out of digit 11 is the carry of the addition.
- R7: start_i is accepted only when busy_o is low. busy_o rises on the next cycle. done_o pulses once, L cycles after the accept edge. L is the number of additions for op codes 0 and 1, 1 for op code 2, and 0 for op code 3 or for a zero-count multiply step.
- R8: When done_o is high, cycles_o equals 42+13n for a multiply step, 37+13*b_o for a divide step, 65 for op code 2 and 0 for op code 3.
- R9: A start_i pulse while busy_o is high, and any change of the operand inputs after acceptance, has no effect on the running operation.
- R10: Op code 3 performs no arithmetic. The unit finishes with every result equal to its input.
- R11: While reset is asserted, every data output, cycles_o, busy_o and done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| op_i | input | 2 | 0 multiply step, 1 divide step, 2 binary multiply, 3 none |
| ar1_i | input | 48 | Addend mantissa, 12 BCD digits |
| ar2_i | input | 48 | Accumulator mantissa, 12 BCD digits |
| a_i | input | 16 | A word operand |
| b_i | input | 16 | B word operand (count for a multiply step) |
| dc_i | input | 1 | Decimal carry flag in |
| ar2_o | output | 48 | Resulting accumulator mantissa |
| a_o | output | 16 | Resulting A word |
| b_o | output | 16 | Resulting B word |
| dc_o | output | 1 | Resulting decimal carry flag |
| cycles_o | output | 8 | Machine-cycle cost of the operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several properties on every cycle. done_o lasts a single cycle and only while busy, and an accepted start always raises busy. At every done they compare the binary product against the captured operands, confirm that a zero-count multiply leaves the accumulator alone, confirm that a divide finishes with a count of at most 15 and either a carry or the cap, and match the multiply cost against the count. The exact decimal sums, the carry counting across digit boundaries, the carry-in taken only on the first addition, and the per-cycle latency need the bench's reference model. The same holds for rejecting a second start and operand changes made mid-run.

// File: rtl/bcd_seq_pkg.sv
package bcd_seq_pkg;
  typedef enum logic [1:0] {
    OP_FMP  = 2'd0,
    OP_FDV  = 2'd1,
    OP_MPY  = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_MUL  = 2'd2,
    ST_FIN  = 2'd3
  } st_e;
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell (
  input  logic [3:0] x_i,
  input  logic [3:0] y_i,
  input  logic       c_i,
  output logic [3:0] s_o,
  output logic       c_o
);
  logic [4:0] raw;
  logic [4:0] adj;

  always_comb begin
    raw = {1'b0, x_i} + {1'b0, y_i} + {4'd0, c_i};
    adj = raw - 5'd10;
    c_o = (raw >= 5'd10);
    s_o = c_o ? adj[3:0] : raw[3:0];
  end
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder #(
  parameter int DIGITS = 12
) (
  input  logic [4*DIGITS-1:0] x_i,
  input  logic [4*DIGITS-1:0] y_i,
  input  logic                c_i,
  output logic [4*DIGITS-1:0] s_o,
  output logic                c_o
);
  logic [DIGITS:0] chain;

  assign chain[0] = c_i;

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    bcd_digit_cell u_cell (
      .x_i (x_i[4*k +: 4]),
      .y_i (y_i[4*k +: 4]),
      .c_i (chain[k]),
      .s_o (s_o[4*k +: 4]),
      .c_o (chain[k+1])
    );
  end

  assign c_o = chain[DIGITS];
endmodule

// File: rtl/smul_unit.sv
module smul_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o
);
  logic signed [2*W-1:0] prod;

  assign prod = $signed(x_i) * $signed(y_i);
  assign lo_o = prod[W-1:0];
  assign hi_o = prod[2*W-1:W];
endmodule

// File: rtl/bcd_muldiv_seq.sv
module bcd_muldiv_seq
  import bcd_seq_pkg::*;
#(
  parameter int DIGITS    = 12,
  parameter int WORD      = 16,
  parameter int CNT_W     = 4,
  parameter int COST_W    = 8,
  parameter int FMP_BASE  = 42,
  parameter int FDV_BASE  = 37,
  parameter int ITER_COST = 13,
  parameter int MPY_COST  = 65
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [1:0]          op_i,
  input  logic [4*DIGITS-1:0] ar1_i,
  input  logic [4*DIGITS-1:0] ar2_i,
  input  logic [WORD-1:0]     a_i,
  input  logic [WORD-1:0]     b_i,
  input  logic                dc_i,
  output logic [4*DIGITS-1:0] ar2_o,
  output logic [WORD-1:0]     a_o,
  output logic [WORD-1:0]     b_o,
  output logic                dc_o,
  output logic [COST_W-1:0]   cycles_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int MANT_W    = 4 * DIGITS;
  localparam int DIV_LAST  = (1 << CNT_W) - 2;  // b value before the cap is reached

  st_e                 st_q;
  op_e                 op_q;
  logic [MANT_W-1:0]   ar1_q, ar2_q;
  logic [WORD-1:0]     a_q, b_q;
  logic                dc_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [COST_W-1:0]   cost_q;

  logic [MANT_W-1:0]   sum;
  logic                carry;
  logic [WORD-1:0]     prod_lo, prod_hi;

  bcd_adder #(.DIGITS(DIGITS)) u_add (
    .x_i (ar2_q),
    .y_i (ar1_q),
    .c_i (dc_q),
    .s_o (sum),
    .c_o (carry)
  );

  smul_unit #(.W(WORD)) u_mul (
    .x_i  (a_q),
    .y_i  (b_q),
    .lo_o (prod_lo),
    .hi_o (prod_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_FMP;
      ar1_q  <= '0;
      ar2_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      dc_q   <= 1'b0;
      cnt_q  <= '0;
      cost_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            op_q  <= op_e'(op_i);
            ar1_q <= ar1_i;
            ar2_q <= ar2_i;
            a_q   <= a_i;
            b_q   <= b_i;
            dc_q  <= dc_i;
            cnt_q <= b_i[CNT_W-1:0];
            unique case (op_e'(op_i))
              OP_FMP: begin
                a_q    <= '0;
                cost_q <= COST_W'(FMP_BASE);
                st_q   <= (b_i[CNT_W-1:0] == '0) ? ST_FIN : ST_ITER;
              end
              OP_FDV: begin
                b_q    <= '0;
                cost_q <= COST_W'(FDV_BASE);
                st_q   <= ST_ITER;
              end
              OP_MPY: begin
                cost_q <= COST_W'(MPY_COST);
                st_q   <= ST_MUL;
              end
              default: begin
                cost_q <= '0;
                st_q   <= ST_FIN;
              end
            endcase
          end
        end
        ST_ITER: begin
          ar2_q <= sum;  // the carrying sum is kept as well
          if (op_q == OP_FMP) begin
            if (carry) a_q <= a_q + WORD'(1);
            dc_q   <= 1'b0;
            cnt_q  <= cnt_q - CNT_W'(1);
            cost_q <= cost_q + COST_W'(ITER_COST);
            if (cnt_q == CNT_W'(1)) st_q <= ST_FIN;
          end else if (carry) begin
            dc_q <= 1'b1;
            st_q <= ST_FIN;
          end else begin
            dc_q   <= 1'b0;
            b_q    <= b_q + WORD'(1);
            cost_q <= cost_q + COST_W'(ITER_COST);
            if (b_q == WORD'(DIV_LAST)) st_q <= ST_FIN;
          end
        end
        ST_MUL: begin
          a_q  <= prod_lo;
          b_q  <= prod_hi;
          st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ar2_o    = ar2_q;
  assign a_o      = a_q;
  assign b_o      = b_q;
  assign dc_o     = dc_q;
  assign cycles_o = cost_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_FIN);
endmodule

// File: rtl/bcd_muldiv_seq_chk.sv
module bcd_muldiv_seq_chk #(
  parameter int DIGITS    = 12,
  parameter int WORD      = 16,
  parameter int CNT_W     = 4,
  parameter int COST_W    = 8,
  parameter int FMP_BASE  = 42,
  parameter int ITER_COST = 13
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [1:0]          op_i,
  input logic [4*DIGITS-1:0] ar2_i,
  input logic [WORD-1:0]     a_i,
  input logic [WORD-1:0]     b_i,
  input logic [4*DIGITS-1:0] ar2_o,
  input logic [WORD-1:0]     a_o,
  input logic [WORD-1:0]     b_o,
  input logic                dc_o,
  input logic [COST_W-1:0]   cycles_o,
  input logic                busy_o,
  input logic                done_o
);
  logic [1:0]              op_c;
  logic [4*DIGITS-1:0]     ar2_c;
  logic [WORD-1:0]         a_c, b_c;
  logic signed [2*WORD-1:0] prod_c;
  logic [CNT_W-1:0]        n_c;
  logic [COST_W-1:0]       fmp_cost_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_c  <= '0;
      ar2_c <= '0;
      a_c   <= '0;
      b_c   <= '0;
    end else if (start_i && !busy_o) begin
      op_c  <= op_i;
      ar2_c <= ar2_i;
      a_c   <= a_i;
      b_c   <= b_i;
    end
  end

  always_comb begin
    prod_c     = $signed(a_c) * $signed(b_c);
    n_c        = b_c[CNT_W-1:0];
    fmp_cost_c = COST_W'(FMP_BASE + ITER_COST * int'(n_c));
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7
  AST_DONE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);  // R7
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);  // R7
  AST_MPY_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_c == 2'd2) |-> ({b_o, a_o} == prod_c));  // R5
  AST_FMP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_c == 2'd0 && n_c == '0) |-> (a_o == '0 && ar2_o == ar2_c));  // R2
  AST_FDV_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_c == 2'd1) |-> (b_o <= WORD'(15) && (dc_o || b_o == WORD'(15))));  // R4
  AST_FMP_COST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_c == 2'd0) |-> (cycles_o == fmp_cost_c));  // R8
endmodule

bind bcd_muldiv_seq bcd_muldiv_seq_chk #(
  .DIGITS(DIGITS), .WORD(WORD), .CNT_W(CNT_W), .COST_W(COST_W),
  .FMP_BASE(FMP_BASE), .ITER_COST(ITER_COST)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .op_i     (op_i),
  .ar2_i    (ar2_i),
  .a_i      (a_i),
  .b_i      (b_i),
  .ar2_o    (ar2_o),
  .a_o      (a_o),
  .b_o      (b_o),
  .dc_o     (dc_o),
  .cycles_o (cycles_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/bcd_muldiv_seq_test.sv
`timescale 1ns/1ps
module bcd_muldiv_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [47:0] ar1_i = '0, ar2_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic        dc_i = 1'b0;
  logic [47:0] ar2_o;
  logic [15:0] a_o, b_o;
  logic        dc_o;
  logic [7:0]  cycles_o;
  logic        busy_o, done_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  bcd_muldiv_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .ar1_i(ar1_i), .ar2_i(ar2_i), .a_i(a_i), .b_i(b_i), .dc_i(dc_i),
    .ar2_o(ar2_o), .a_o(a_o), .b_o(b_o), .dc_o(dc_o),
    .cycles_o(cycles_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference decimal add, digit by digit (R6)
  function automatic logic [47:0] ref_add(input logic [47:0] x, input logic [47:0] y,
                                          input bit ci, output bit co);
    logic [47:0] r;
    int c;
    c = ci;
    r = '0;
    for (int k = 0; k < 12; k++) begin
      int d;
      d = int'(x[4*k +: 4]) + int'(y[4*k +: 4]) + c;
      if (d >= 10) begin d -= 10; c = 1; end else c = 0;
      r[4*k +: 4] = 4'(d);
    end
    co = (c != 0);
    return r;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [47:0] r1, input logic [47:0] r2,
                        input logic [15:0] ia, input logic [15:0] ib, input bit idc,
                        input string req, input bit poke);
    logic [47:0] e_ar2;
    logic [15:0] e_a, e_b;
    bit          e_dc, co;
    int          e_cost, lat;
    logic signed [31:0] p;
    e_ar2 = r2; e_a = ia; e_b = ib; e_dc = idc; e_cost = 0; lat = 0;
    case (op)
      2'd0: begin
        int n;
        n = ib[3:0];
        e_a = 0;
        for (int k = 0; k < n; k++) begin
          e_ar2 = ref_add(e_ar2, r1, e_dc, co);
          if (co) e_a++;
          e_dc = 0;
        end
        lat = n; e_cost = 42 + 13 * n;
      end
      2'd1: begin
        e_b = 0;
        while (e_b < 15) begin
          e_ar2 = ref_add(e_ar2, r1, e_dc, co);
          lat++;
          if (co) begin e_dc = 1; break; end
          e_dc = 0;
          e_b++;
        end
        e_cost = 37 + 13 * int'(e_b);
      end
      2'd2: begin
        p = $signed(ia) * $signed(ib);
        e_a = p[15:0]; e_b = p[31:16]; lat = 1; e_cost = 65;
      end
      default: begin lat = 0; e_cost = 0; end
    endcase

    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    op_i = op; ar1_i = r1; ar2_i = r2; a_i = ia; b_i = ib; dc_i = idc; start_i = 1'b1;
    @(posedge clk_i);
    #1;
    start_i = 1'b0;
    // scramble inputs after acceptance (R9)
    ar1_i = ~r1; ar2_i = ~r2; a_i = ~ia; b_i = ~ib; dc_i = ~idc; op_i = ~op;
    for (int i = 0; i <= lat; i++) begin
      @(negedge clk_i);
      start_i = (poke && i == 0 && lat > 0);  // second start while busy (R9)
      chk(busy_o == 1'b1, {req, " R7 busy"}, 64'(busy_o), 64'd1);
      chk(done_o == (i == lat), {req, " R7 done timing"}, 64'(done_o), 64'(i == lat));
      if (i == lat) begin
        chk(ar2_o == e_ar2, {req, " ar2"}, 64'(ar2_o), 64'(e_ar2));
        chk(a_o == e_a, {req, " a"}, 64'(a_o), 64'(e_a));
        chk(b_o == e_b, {req, " b"}, 64'(b_o), 64'(e_b));
        chk(dc_o == e_dc, {req, " dc"}, 64'(dc_o), 64'(e_dc));
        chk(int'(cycles_o) == e_cost, {req, " R8 cost"}, 64'(cycles_o), 64'(e_cost));
      end
    end
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b0 && done_o == 1'b0, {req, " R7 idle after done"},
        64'({busy_o, done_o}), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(ar2_o == '0 && a_o == '0 && b_o == '0 && dc_o == 1'b0, "R11 data", 64'(a_o), 64'd0);
    chk(cycles_o == '0 && !busy_o && !done_o, "R11 ctrl", 64'({cycles_o, busy_o, done_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_op(2'd0, 48'h500000000000, 48'h600000000000, 16'h1234, 16'h0003, 1'b0, "R1 carries", 0);
    run_op(2'd0, 48'h000000000999, 48'h123456789001, 16'h0000, 16'hABC2, 1'b1, "R1 carry-in", 0);
    run_op(2'd0, 48'h000000000001, 48'h099999999999, 16'h0000, 16'h0001, 1'b0, "R6 digit ripple", 0);
    run_op(2'd0, 48'h999999999999, 48'h000000000000, 16'hFFFF, 16'h000F, 1'b0, "R1 count 15", 0);
    run_op(2'd0, 48'h123123123123, 48'h456456456456, 16'h7777, 16'h0010, 1'b1, "R2 zero count", 0);
    run_op(2'd1, 48'h900000000000, 48'h100000000000, 16'h5555, 16'h00FF, 1'b0, "R3 first pass carry", 0);
    run_op(2'd1, 48'h100000000000, 48'h500000000000, 16'h0042, 16'h0009, 1'b0, "R3 five passes", 0);
    run_op(2'd1, 48'h000000000000, 48'h000000000123, 16'h0001, 16'h0000, 1'b1, "R4 cap", 0);
    run_op(2'd2, 48'h0, 48'h987654321098, 16'h0007, 16'hFFFD, 1'b1, "R5 pos neg", 0);
    run_op(2'd2, 48'h0, 48'h000000000000, 16'h8000, 16'h8000, 1'b0, "R5 min min", 0);
    run_op(2'd2, 48'h0, 48'h111111111111, 16'hFB2E, 16'hE9D2, 1'b0, "R5 neg neg", 0);
    run_op(2'd3, 48'h222222222222, 48'h333333333333, 16'hCAFE, 16'hBEEF, 1'b1, "R10 none", 0);
    run_op(2'd0, 48'h000000000001, 48'h000000000002, 16'h0000, 16'h0005, 1'b0, "R9 start while busy", 1);
    run_op(2'd1, 48'h300000000000, 48'h100000000000, 16'h0003, 16'h0000, 1'b1, "R3 carry-in pass", 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule